// File: doc/BRIEF.md
# USB Line-State Generator with High-Speed Idle Timer

This block forms the two-bit line-state code that a UTMI-style transceiver reports to its link controller. It takes the transceiver-select and termination-select controls, the sampled single-ended levels of the two data lines, the high-speed squelch flag and the output of the high-speed differential receiver. Every input is asynchronous to the PHY clock, so all of them pass through one two-flop synchroniser bank.

The synchronised selects choose one of three interpretations:

- **Full-speed:** the single-ended levels are reported directly.
- **High-speed:** only squelch decides the code, so the code toggles as little as possible.
- **Chirp:** squelch qualifies the differential receiver.

The chosen mode and the code are debounced together. A new pair is accepted only after it has been steady for two consecutive clocks.

A cycle counter watches for a continuous idle (squelched) line while in high-speed mode. After a parameterised number of PHY clocks it raises a bus-reset-detect flag. The default is 180000 cycles, which is 3 ms at 60 MHz. The flag holds until the line leaves idle.

Top module: `usb_linestate_gen`

## Requirements
- R1: With transceiver select 1 and termination select 1, the line state is {dm, dp}: 00 for SE0, 01 for J (dp high), 10 for K (dm high), 11 for SE1. Squelch and the differential receiver have no effect.
- R2: With transceiver select 1 and termination select 0, the same full-speed encoding {dm, dp} applies.
- R3: With both selects 0 (high-speed), the line state is 00 when squelch is 1 and 01 when squelch is 0. It is never 10 or 11, whatever the dp, dm and differential receiver inputs are.
- R4: With transceiver select 0 and termination select 1 (chirp), the line state is 00 whenever squelch is 1. Otherwise it is 01 when the differential receiver is 1 (J) and 10 when it is 0 (K).
- R5: An input change held steady is first seen on the line state after exactly 5 rising clock edges. It is not yet seen after 4.
- R6: An input pulse lasting one clock does not change the line state.
- R7: An input change lasting two clocks is accepted onto the line state.
- R8: While rst_n is low and right after reset, the line state is 00 and the reset-detect flag is 0.
- R9: The reset-detect flag is 1 exactly IDLE_CYCLES clocks after the line state first shows high-speed idle (mode high-speed, code 00). It is 0 one clock earlier.
- R10: The reset-detect flag stays 1 while high-speed idle lasts. It falls in the same cycle that the line state leaves 00.
- R11: Any non-idle line state, or any mode change, restarts the idle count from zero.
- R12: An idle-looking code 00 in full-speed or chirp mode never raises the reset-detect flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xcvr_sel_i | input | 1 | 1 selects full-speed thresholds, 0 selects high-speed interpretation |
| term_sel_i | input | 1 | Termination select (1 with transceiver select 0 means chirp) |
| dp_i | input | 1 | Single-ended D+ level |
| dm_i | input | 1 | Single-ended D- level |
| squelch_i | input | 1 | High-speed squelch detected |
| hs_rx_i | input | 1 | High-speed differential receiver output (1 = J) |
| line_state_o | output | 2 | Debounced line-state code |
| hs_reset_o | output | 1 | High-speed idle reset detected |

## Verification
The hardest situation to reach is an idle count that is cut short by a brief non-idle interval. The interval must be long enough to pass the debouncer yet short enough to stay far below the terminal count. The bench shortens IDLE_CYCLES through its parameter and starts an idle run. Partway through, it lifts squelch for three clocks, so that code 01 is accepted. It then squelches again and times the flag against the second entry into idle, not the first. One-clock and two-clock input pulses separately probe the edge of the debounce window.

// File: rtl/usb_ls_pkg.sv
package usb_ls_pkg;

  typedef enum logic [1:0] {
    MODE_HS    = 2'd0,
    MODE_CHIRP = 2'd1,
    MODE_FS    = 2'd2
  } ls_mode_e;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  // Interpretation picked by the two select controls
  function automatic ls_mode_e mode_of(input logic xcvr, input logic term);
    if (xcvr) return MODE_FS;
    return term ? MODE_CHIRP : MODE_HS;
  endfunction

  // Line-state code for a given interpretation
  function automatic logic [1:0] encode_ls(input ls_mode_e mode, input logic dp,
                                           input logic dm, input logic sq,
                                           input logic hsrx);
    case (mode)
      MODE_FS:    return {dm, dp};
      MODE_CHIRP: return sq ? LS_SE0 : (hsrx ? LS_J : LS_K);
      default:    return sq ? LS_SE0 : LS_J;
    endcase
  endfunction

endpackage

// File: rtl/ls_sync.sv
module ls_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= async_i;
        else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ls_debounce.sv
module ls_debounce #(
  parameter int             WIDTH     = 4,
  parameter int             STABLE    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] stable_o
);
  logic [STABLE-1:0][WIDTH-1:0] hist_q;
  logic                         all_same;
  logic [WIDTH-1:0]             out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= {STABLE{RESET_VAL}};
    else        hist_q <= {hist_q[STABLE-2:0], raw_i};
  end

  always_comb begin
    all_same = 1'b1;
    for (int i = 1; i < STABLE; i++)
      if (hist_q[i] != hist_q[0]) all_same = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= RESET_VAL;
    else if (all_same) out_q <= hist_q[0];
  end

  assign stable_o = out_q;

  // R6
  deb_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> $past(all_same));
endmodule

// File: rtl/ls_idle_timer.sv
module ls_idle_timer
  import usb_ls_pkg::*;
#(
  parameter int IDLE_CYCLES = 180000,
  localparam int CW = $clog2(IDLE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ls_mode_e   mode_i,
  input  logic [1:0] code_i,
  output logic       hs_reset_o
);
  localparam logic [CW-1:0] TERM = CW'(IDLE_CYCLES);

  ls_mode_e        mode_prev_q;
  logic [CW-1:0]   cnt_q;
  logic            hs_idle;
  logic            mode_change;

  assign hs_idle     = (mode_i == MODE_HS) && (code_i == LS_SE0);
  assign mode_change = (mode_i != mode_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_prev_q <= MODE_FS;
      cnt_q       <= '0;
    end else begin
      mode_prev_q <= mode_i;
      if (!hs_idle || mode_change) cnt_q <= '0;
      else if (cnt_q != TERM)      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hs_reset_o = hs_idle && (cnt_q == TERM);

  // R11
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_idle |=> (cnt_q == '0));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TERM);
endmodule

// File: rtl/usb_linestate_gen.sv
module usb_linestate_gen
  import usb_ls_pkg::*;
#(
  parameter int IDLE_CYCLES  = 180000,
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_COUNT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xcvr_sel_i,
  input  logic       term_sel_i,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       squelch_i,
  input  logic       hs_rx_i,
  output logic [1:0] line_state_o,
  output logic       hs_reset_o
);
  localparam int NIN = 6;
  localparam int WW  = 4;

  logic [NIN-1:0] async_bus, sync_bus;
  ls_mode_e       raw_mode, deb_mode;
  logic [1:0]     raw_code;
  logic [WW-1:0]  raw_word, deb_word;

  assign async_bus = {xcvr_sel_i, term_sel_i, dp_i, dm_i, squelch_i, hs_rx_i};

  ls_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(async_bus), .sync_o(sync_bus)
  );

  assign raw_mode = mode_of(sync_bus[5], sync_bus[4]);
  assign raw_code = encode_ls(raw_mode, sync_bus[3], sync_bus[2], sync_bus[1], sync_bus[0]);
  assign raw_word = {raw_mode, raw_code};

  ls_debounce #(.WIDTH(WW), .STABLE(STABLE_COUNT), .RESET_VAL({MODE_FS, LS_SE0})) u_deb (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_word), .stable_o(deb_word)
  );

  assign deb_mode     = ls_mode_e'(deb_word[3:2]);
  assign line_state_o = deb_word[1:0];

  ls_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .mode_i(deb_mode), .code_i(deb_word[1:0]),
    .hs_reset_o(hs_reset_o)
  );

  // R3
  hs_no_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_mode == MODE_HS) |-> !line_state_o[1]);

  // R12
  fs_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_mode != MODE_HS) |-> !hs_reset_o);

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_reset_o |-> (line_state_o == LS_SE0));
endmodule

// File: tb/usb_linestate_gen_tb.sv
module usb_linestate_gen_tb;
  localparam int N = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xcvr = 1'b1, term = 1'b1, dp = 1'b0, dm = 1'b0, sq = 1'b0, hsrx = 1'b0;
  logic [1:0] ls;
  logic hsr;
  int tests = 0, fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  usb_linestate_gen #(.IDLE_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .xcvr_sel_i(xcvr), .term_sel_i(term),
    .dp_i(dp), .dm_i(dm), .squelch_i(sq), .hs_rx_i(hsrx),
    .line_state_o(ls), .hs_reset_o(hsr)
  );

  // {xcvr, term, dp, dm, squelch, hs_rx, expected[1:0]}
  localparam logic [7:0] VEC [16] = '{
    8'b11000000, 8'b11100001, 8'b11010010, 8'b11110011,
    8'b11101001, 8'b10010010, 8'b10110011, 8'b00111100,
    8'b00010001, 8'b00000101, 8'b00001000, 8'b01000101,
    8'b01000010, 8'b01001100, 8'b01001000, 8'b01110010
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ls(input logic [1:0] v);
    int k = 0;
    while (ls != v && k < 50) begin @(negedge clk); k++; end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    cycles(3);
    check(ls == 2'b00, "R8 line state in reset", ls, 0);
    check(hsr == 1'b0, "R8 flag in reset", hsr, 0);
    rst_n = 1'b1;
    cycles(1);
    check(ls == 2'b00 && hsr == 1'b0, "R8 after reset", {ls, hsr}, 0);

    // R1 R2 R3 R4 table walk
    foreach (VEC[i]) begin
      {xcvr, term, dp, dm, sq, hsrx} = VEC[i][7:2];
      cycles(8);
      check(ls == VEC[i][1:0], $sformatf("R1/R2/R3/R4 vector %0d", i), ls, VEC[i][1:0]);
      check(hsr == 1'b0, "R12 no flag during walk", hsr, 0);
    end

    // R5 latency: FS J -> K
    {xcvr, term, dp, dm, sq, hsrx} = 6'b111000;
    cycles(8);
    {dp, dm} = 2'b01;
    cycles(4);
    check(ls == 2'b01, "R5 not yet after 4 edges", ls, 1);
    cycles(1);
    check(ls == 2'b10, "R5 seen after 5 edges", ls, 2);

    // R6 one-clock glitch ignored
    cycles(4);
    {dp, dm} = 2'b10;
    cycles(1);
    {dp, dm} = 2'b01;
    for (int k = 0; k < 8; k++) begin
      cycles(1);
      check(ls == 2'b10, "R6 glitch ignored", ls, 2);
    end

    // R7 two-clock change accepted
    {dp, dm} = 2'b10;
    cycles(2);
    {dp, dm} = 2'b01;
    wait_ls(2'b01);
    check(ls == 2'b01, "R7 two-clock pulse accepted", ls, 1);
    cycles(8);
    check(ls == 2'b10, "R7 returns afterwards", ls, 2);

    // R12 full-speed SE0 and chirp squelch never flag
    {xcvr, term, dp, dm, sq, hsrx} = 6'b110000;
    for (int k = 0; k < 2*N; k++) begin
      cycles(1);
      if (hsr) check(1'b0, "R12 FS SE0 no flag", hsr, 0);
    end
    check(hsr == 1'b0 && ls == 2'b00, "R12 FS SE0 long", hsr, 0);
    {xcvr, term, dp, dm, sq, hsrx} = 6'b010010;
    for (int k = 0; k < 2*N; k++) begin
      cycles(1);
      if (hsr) check(1'b0, "R12 chirp squelch no flag", hsr, 0);
    end
    check(hsr == 1'b0 && ls == 2'b00, "R12 chirp squelch long", hsr, 0);

    // R9 terminal count in high-speed idle
    {xcvr, term, dp, dm, sq, hsrx} = 6'b000000;
    cycles(8);
    check(ls == 2'b01, "R3 HS unsquelched", ls, 1);
    sq = 1'b1;
    wait_ls(2'b00);
    cycles(N-1);
    check(hsr == 1'b0, "R9 one before terminal", hsr, 0);
    cycles(1);
    check(hsr == 1'b1, "R9 at terminal", hsr, 1);
    cycles(10);
    check(hsr == 1'b1, "R10 holds while idle", hsr, 1);

    // R10 falls with line state
    sq = 1'b0;
    wait_ls(2'b01);
    check(hsr == 1'b0, "R10 falls when idle ends", hsr, 0);

    // R11 interrupted idle restarts
    cycles(8);
    sq = 1'b1;
    wait_ls(2'b00);
    cycles(N-10);
    sq = 1'b0;
    cycles(3);
    sq = 1'b1;
    wait_ls(2'b01);
    check(ls == 2'b01, "R11 interruption seen", ls, 1);
    wait_ls(2'b00);
    cycles(N-1);
    check(hsr == 1'b0, "R11 restarted count one before", hsr, 0);
    cycles(1);
    check(hsr == 1'b1, "R11 restarted count terminal", hsr, 1);

    // R11 mode change: HS idle -> chirp squelch -> HS idle
    term = 1'b1;
    cycles(8);
    check(hsr == 1'b0 && ls == 2'b00, "R11 mode change clears flag", hsr, 0);
    term = 1'b0;
    cycles(4);
    cycles(N-6);
    check(hsr == 1'b0, "R11 count restarted after mode change", hsr, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule